// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Sixteenth-Step Stop Period

This block turns characters written by a host into an asynchronous serial frame on a single output line. The line rests high. Each character goes out as a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. A programmable divider of the system clock produces a x16 oversampling tick. The start, data and parity bits each last 16 ticks. The stop period is set in sixteenths of a bit, from 9/16 bit up to 2 bits. Parity can be none, even, odd, or forced to a fixed level.

A one-character holding register sits in front of the shift stage, so the host can queue the next character while the current one is on the line. Two status outputs report the state: `tx_ready` means the holding register can take a write, and `tx_empty` means nothing is pending and nothing is being sent. A break request holds the line low. It takes effect only once the character in flight has finished, and it lasts until the request is removed.

The serializer is a state machine with six states:
- `S_IDLE`: line high.
- `S_START`: start bit.
- `S_DATA`: data bits.
- `S_PARITY`: parity bit.
- `S_STOP`: stop period.
- `S_BREAK`: line held low.

Its transitions are:
- IDLE→BREAK when a break is requested.
- IDLE→START when a character is loaded from the holding register.
- START→DATA after 16 ticks.
- DATA→PARITY after the last data bit if parity is enabled; otherwise DATA→STOP.
- PARITY→STOP after 16 ticks.
- STOP→IDLE when the stop count expires.
- BREAK→IDLE when the request is removed.

Top module: `uart_tx_frac`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1 and `tx_empty` is 1.
- R2: The x16 tick occurs once every `baud_div`+1 clock cycles, counted from reset. A `baud_div` of 0 gives a tick on every cycle.
- R3: A frame is a low start bit, then the data bits with the least significant bit first, then the optional parity bit, then a high stop period. The start, data and parity bits each last 16 ticks.
- R4: `data_len` sets the number of data bits: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length are not sent.
- R5: `par_mode` selects the parity. Code 0 sends no parity bit. Code 1 is even: the bit makes the count of ones in the sent data plus parity even. Code 2 is odd. Code 3 sends `par_level` as the parity bit.
- R6: `stop_code` values 0 to 7 give a stop period of (9+code) ticks. Values 8 to 15 give (17+code) ticks, that is 25 to 32 ticks.
- R7: A write (`wr_en`=1) is accepted only while `tx_ready` is 1, and `tx_ready` is 0 in the cycle after an accepted write. A write while `tx_ready` is 0 is ignored, and that character never appears on `txd`.
- R8: The shift stage loads a held character in the clock edge after it finds the character pending and the line is idle. The start bit appears in the cycle after the load. `tx_empty` is 1 only when the holding register is empty and the shift stage is idle.
- R9: A break request received during a frame waits until that frame's stop period ends. `txd` then stays 0 until `brk_req` is removed, and only after that is a pending character sent.
- R10: Length, parity mode, parity level and stop code are captured when a character is loaded. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_div | input | 16 | Tick divider; tick period is baud_div+1 clocks |
| data_len | input | 2 | Data length code (5 + code bits) |
| par_mode | input | 2 | Parity code: 0 none, 1 even, 2 odd, 3 forced |
| par_level | input | 1 | Parity bit value in forced mode |
| stop_code | input | 4 | Stop period code in sixteenths |
| brk_req | input | 1 | Request to hold the line low |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output, idles high |
| tx_ready | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Holding register and shift stage are both idle |

## Verification
The bench compares every output on every clock against a behavioural model. The model turns each loaded character into a list of line levels and tick counts. Stimuli and what each one separates:
- An alternating data pattern with no parity tells LSB-first order from MSB-first order.
- Characters at all four lengths, each with a different parity code, show whether truncation and the parity value are right.
- Stop codes 0, 8 and 15 catch off-by-one errors at both ends of the two stop ranges.
- Back-to-back writes, and a write while full, check the holding register.
- A break raised mid-frame and a configuration change mid-frame check the ordering and capture rules.
- A divider of 0 checks the every-cycle tick.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;
    localparam int OVERSAMPLE = 16;
    localparam int TCNT_W     = $clog2(2 * OVERSAMPLE + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PARITY, S_STOP, S_BREAK
    } txf_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2, PAR_FORCE = 2'd3
    } txf_par_e;

    function automatic logic [TCNT_W-1:0] stop_ticks(input logic [3:0] code);
        logic [TCNT_W-1:0] c;
        c = TCNT_W'(code);
        return code[3] ? c + TCNT_W'(17) : c + TCNT_W'(9);
    endfunction
endpackage

// File: rtl/uart_txf_tick.sv
module uart_txf_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R2: with a nonzero divisor, two ticks never fall on adjacent cycles
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/uart_txf_hold.sv
module uart_txf_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R7: the register only fills as the result of a write
    a_r7_fill_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(wr_en));
    // R7: a write while full leaves the held character unchanged
    a_r7_full_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> $stable(data));
endmodule

// File: rtl/uart_txf_ser.sv
module uart_txf_ser
    import uart_txf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [1:0]        data_len,
    input  logic [1:0]        par_mode,
    input  logic              par_level,
    input  logic [3:0]        stop_code,
    input  logic              brk_req,
    output logic              load,
    output logic              idle,
    output logic              txd
);
    localparam int BIDX_W = $clog2(DATA_W);

    txf_state_e        state, state_nx;
    logic [TCNT_W-1:0] tcnt, stop_len;
    logic [BIDX_W-1:0] bidx, last_bit;
    logic [DATA_W-1:0] shreg, masked;
    logic              par_bit, par_on, seg_end;

    assign load    = (state == S_IDLE) && !brk_req && hold_full;
    assign seg_end = tick && (tcnt == ((state == S_STOP) ? stop_len - 1'b1
                                                         : TCNT_W'(OVERSAMPLE - 1)));
    assign masked  = hold_data & (DATA_W'({DATA_W{1'b1}}) >> (2'd3 - data_len));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (brk_req) state_nx = S_BREAK;
                      else if (hold_full) state_nx = S_START;
            S_START:  if (seg_end) state_nx = S_DATA;
            S_DATA:   if (seg_end && bidx == last_bit)
                          state_nx = par_on ? S_PARITY : S_STOP;
            S_PARITY: if (seg_end) state_nx = S_STOP;
            S_STOP:   if (seg_end) state_nx = S_IDLE;
            S_BREAK:  if (!brk_req) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt     <= '0;
            bidx     <= '0;
            last_bit <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            par_on   <= 1'b0;
            stop_len <= '0;
        end else if (load) begin
            tcnt     <= '0;
            bidx     <= '0;
            last_bit <= BIDX_W'(data_len) + BIDX_W'(4);
            shreg    <= masked;
            par_on   <= (par_mode != PAR_NONE);
            stop_len <= stop_ticks(stop_code);
            unique case (par_mode)
                PAR_EVEN:  par_bit <= ^masked;
                PAR_ODD:   par_bit <= ~^masked;
                PAR_FORCE: par_bit <= par_level;
                default:   par_bit <= 1'b0;
            endcase
        end else if (seg_end) begin
            tcnt <= '0;
            if (state == S_DATA) begin
                bidx  <= bidx + 1'b1;
                shreg <= shreg >> 1;
            end
        end else if (tick && state != S_IDLE && state != S_BREAK) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    always_comb begin
        idle = (state == S_IDLE);
        unique case (state)
            S_START, S_BREAK: txd = 1'b0;
            S_DATA:           txd = shreg[0];
            S_PARITY:         txd = par_bit;
            default:          txd = 1'b1;
        endcase
    end

    // R3: a load is followed by the start bit on the next cycle
    a_r3_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd);
    // R6: the stop counter never passes the captured stop length
    a_r6_stop_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP) |-> (tcnt < stop_len));
    // R9: a break raised mid-frame does not cut the frame short
    a_r9_break_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && state == S_DATA) |=> state != S_BREAK);
endmodule

// File: rtl/uart_tx_frac.sv
module uart_tx_frac #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [1:0]        data_len,
    input  logic [1:0]        par_mode,
    input  logic              par_level,
    input  logic [3:0]        stop_code,
    input  logic              brk_req,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty
);
    logic              tick, load, hold_full, ser_idle;
    logic [DATA_W-1:0] hold_data;

    uart_txf_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    uart_txf_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .take(load), .full(hold_full), .data(hold_data)
    );

    uart_txf_ser #(.DATA_W(DATA_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .hold_full(hold_full), .hold_data(hold_data),
        .data_len(data_len), .par_mode(par_mode), .par_level(par_level),
        .stop_code(stop_code), .brk_req(brk_req),
        .load(load), .idle(ser_idle), .txd(txd)
    );

    assign tx_ready = !hold_full;
    assign tx_empty = !hold_full && ser_idle;

    // R8: empty implies the holding register can accept a write
    a_r8_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready);
    // R7: an accepted write makes the block not ready on the next cycle
    a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_ready) |=> !tx_ready);
endmodule

// File: tb/sim_uart_tx_frac.sv
module sim_uart_tx_frac;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic [15:0] baud_div = 16'd2;
    logic [1:0]  data_len = 2'd3, par_mode = 2'd0;
    logic        par_level = 1'b0, brk_req = 1'b0, wr_en = 1'b0;
    logic [3:0]  stop_code = 4'd7;
    logic [7:0]  wr_data = 8'h00;
    logic        txd, tx_ready, tx_empty;

    always #2.5 clk = ~clk;

    uart_tx_frac u0 (.*);

    int vectors = 0, errors = 0, cycles = 0;
    string phase = "R1";

    // behavioural reference model
    int m_cnt, m_mode, m_done;
    bit m_full;
    logic [7:0] m_data;
    int lvl_q[$], len_q[$];

    task automatic build_frame(input logic [7:0] d);
        int n;
        bit p;
        n = 5 + int'(data_len);
        p = 1'b0;
        lvl_q.push_back(0); len_q.push_back(16);
        for (int i = 0; i < n; i++) begin
            lvl_q.push_back(int'(d[i])); len_q.push_back(16);
            p = p ^ d[i];
        end
        if (par_mode != 2'd0) begin
            lvl_q.push_back(par_mode == 2'd1 ? int'(p) :
                            par_mode == 2'd2 ? int'(!p) : int'(par_level));
            len_q.push_back(16);
        end
        lvl_q.push_back(1);
        len_q.push_back(stop_code < 4'd8 ? 9 + int'(stop_code) : 17 + int'(stop_code));
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mode = 0; m_done = 0; m_full = 0; m_data = 0;
            lvl_q.delete(); len_q.delete();
        end else begin
            bit tk, old_full;
            tk = (m_cnt >= int'(baud_div));
            old_full = m_full;
            case (m_mode)
                0: if (brk_req) m_mode = 2;
                   else if (old_full) begin
                       build_frame(m_data); m_full = 0; m_mode = 1; m_done = 0;
                   end
                1: if (tk) begin
                       m_done++;
                       if (m_done == len_q[0]) begin
                           void'(lvl_q.pop_front()); void'(len_q.pop_front());
                           m_done = 0;
                           if (len_q.size() == 0) m_mode = 0;
                       end
                   end
                default: if (!brk_req) m_mode = 0;
            endcase
            if (wr_en && !old_full) begin m_full = 1; m_data = wr_data; end
            m_cnt = tk ? 0 : m_cnt + 1;
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(phase, "txd", txd, m_mode == 1 ? lvl_q[0][0] : (m_mode == 2 ? 1'b0 : 1'b1));
            check(phase, "tx_ready", tx_ready, !m_full);
            check(phase, "tx_empty", tx_empty, !m_full && m_mode == 0);
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic put(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(m_mode == 0 && !m_full)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset txd", txd, 1'b1);
        check("R1", "reset tx_ready", tx_ready, 1'b1);
        check("R1", "reset tx_empty", tx_empty, 1'b1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        phase = "R3"; put(8'hA5); wait_idle();
        phase = "R2"; put(8'h3C); wait_idle();

        phase = "R4"; data_len = 2'd0; par_mode = 2'd1; put(8'hF3); wait_idle();
        phase = "R5"; data_len = 2'd1; par_mode = 2'd2; put(8'h2D); wait_idle();
        data_len = 2'd2; par_mode = 2'd3; par_level = 1'b1; put(8'h41); wait_idle();
        data_len = 2'd3; par_mode = 2'd1; put(8'h81); wait_idle();
        par_mode = 2'd3; par_level = 1'b0; put(8'hFF); wait_idle();

        phase = "R6"; par_mode = 2'd0;
        stop_code = 4'd0;  put(8'h00); wait_idle();
        stop_code = 4'd8;  put(8'hFF); wait_idle();
        stop_code = 4'd15; put(8'h55); wait_idle();

        phase = "R7"; stop_code = 4'd3;
        put(8'h11);
        put(8'h22);
        check("R7", "not ready after write while shifting", tx_ready, 1'b0);
        put(8'hEE);
        phase = "R8"; wait_idle();

        phase = "R9";
        put(8'h96);
        repeat (200) @(negedge clk);
        brk_req = 1'b1;
        put(8'h69);
        repeat (700) @(negedge clk);
        check("R9", "line low during break", txd, 1'b0);
        brk_req = 1'b0;
        wait_idle();

        phase = "R10";
        put(8'hC3);
        repeat (100) @(negedge clk);
        data_len = 2'd0; par_mode = 2'd2; stop_code = 4'd12;
        wait_idle();

        phase = "R2"; baud_div = 16'd0;
        put(8'h5A); put(8'hA5); wait_idle();
        baud_div = 16'd4; put(8'h0F); wait_idle();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule